// File: doc/BRIEF.md
# Digital AGC with slew-limited gain

This block applies one common gain to a stream of complex baseband samples. It sits between a lowpass channel filter and a polyphase resampler. Each accepted I/Q pair is multiplied by a mantissa, scaled down by 2^(mantissa width - 1), shifted left by an exponent and saturated to the signed output width. The result appears on a registered output stream.

The gain can come from two sources. In held mode it is a value written by the host. In loop mode the block measures |I| + |Q| of every scaled output sample and compares it with a target level. It then steps the gain down or up by a programmable slew amount, and clamps the result between a programmable floor and ceiling. The live gain code is always driven on a level output, so a downstream output selector can deliver it as a data word.

Top module: `agc_scaler`

## Requirements
- R1: After reset the output valid is low, the block is in held mode and the gain code on `level_o` is 0x080 (unity).
- R2: For each accepted sample x on either rail, the output is sat16(floor(x * m / 128) * 2^e). The gain code is laid out as exponent e in bits [11:8] and mantissa m in bits [7:0].
- R3: A scaled value above 32767 is output as 32767, and one below -32768 is output as -32768.
- R4: `out_valid_o` is high exactly two clock edges after the edge that sampled `in_valid_i` high, and is low otherwise.
- R5: In held mode the gain is the held register. A new value written to it applies to the first sample accepted after the write edge.
- R6: In loop mode, each output sample with level |I|+|Q| above the target lowers the gain code by the slew amount, with a floor at 0. A level below the target raises it by the slew amount, capped at 0xFFF. An equal level leaves it unchanged. The update is applied on the edge after the output sample, and the gain is unchanged while no output sample is produced.
- R7: After each loop update the gain code is clamped to the ceiling, then to the floor.
- R8: When the floor exceeds the ceiling, every loop update yields the floor.
- R9: On entering loop mode the gain starts from the held value.
- R10: `level_o` always shows the gain code that the next accepted sample will use.
- R11: The configuration registers are written on a clock edge with `cfg_we_i` high. Address 0 bit 0 selects the mode (1 = loop). Address 1 is the held gain, address 2 the ceiling, address 3 the floor, address 4 the slew (all [11:0]), and address 5 the target level ([15:0]). Writes to addresses 6 and 7 are ignored.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample qualifier |
| in_i_i | input | 16 | Input in-phase sample, signed |
| in_q_i | input | 16 | Input quadrature sample, signed |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 16 | Configuration write data |
| out_valid_o | output | 1 | Output sample qualifier |
| out_i_o | output | 16 | Scaled in-phase sample, signed |
| out_q_o | output | 16 | Scaled quadrature sample, signed |
| level_o | output | 12 | Live gain code {exponent, mantissa} |

## Verification
The limit and inverted-limit properties apply only to updates where the mode, ceiling and floor did not change across the update edge. They take no position on a write that lands on the same edge as an update. The bench writes configuration at random times during loop operation, so such coincidences happen. The reference model therefore mirrors edge ordering exactly: each update uses the pre-edge register values. The bench writes all eight addresses, including the two that are ignored, and keeps the valid input a clean single-cycle strobe per sample.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int GAIN_EXP_W = 4;
  localparam int GAIN_MAN_W = 8;
  localparam int GAIN_W     = GAIN_EXP_W + GAIN_MAN_W;
  localparam int CFG_AW     = 3;
  localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1) << (GAIN_MAN_W - 1);

  typedef enum logic [CFG_AW-1:0] {
    CFG_MODE   = 3'd0,
    CFG_HELD   = 3'd1,
    CFG_CEIL   = 3'd2,
    CFG_FLOOR  = 3'd3,
    CFG_SLEW   = 3'd4,
    CFG_TARGET = 3'd5
  } cfg_addr_e;
endpackage

// File: rtl/agc_cfg_regs.sv
module agc_cfg_regs
  import agc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              auto_o,
  output logic [GAIN_W-1:0] held_o,
  output logic [GAIN_W-1:0] ceil_o,
  output logic [GAIN_W-1:0] floor_o,
  output logic [GAIN_W-1:0] slew_o,
  output logic [DW-1:0]     target_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_o   <= 1'b0;
      held_o   <= GAIN_UNITY;
      ceil_o   <= '1;
      floor_o  <= '0;
      slew_o   <= GAIN_W'(1);
      target_o <= DW'(1) << (DW - 2);
    end else if (we_i) begin
      case (addr_i)
        CFG_MODE:   auto_o   <= wdata_i[0];
        CFG_HELD:   held_o   <= wdata_i[GAIN_W-1:0];
        CFG_CEIL:   ceil_o   <= wdata_i[GAIN_W-1:0];
        CFG_FLOOR:  floor_o  <= wdata_i[GAIN_W-1:0];
        CFG_SLEW:   slew_o   <= wdata_i[GAIN_W-1:0];
        CFG_TARGET: target_o <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/agc_scale_lane.sv
module agc_scale_lane #(
  parameter int DW = 16,
  parameter int MW = 8,
  parameter int EW = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 s1_en_i,
  input  logic                 s2_en_i,
  input  logic signed [DW-1:0] x_i,
  input  logic [MW-1:0]        man_i,
  input  logic [EW-1:0]        exp_i,
  output logic signed [DW-1:0] y_o
);
  localparam int PW = DW + MW + 1;
  localparam int AW = DW + 2;
  localparam int SW = AW + (1 << EW) - 1;

  logic signed [PW-1:0] prod, prod_sh;
  logic signed [AW-1:0] acc_q;
  logic [EW-1:0]        exp_q;
  logic signed [SW-1:0] ext, wide;
  logic                 ovf;
  logic                 unused_hi;

  assign prod      = x_i * $signed({1'b0, man_i});
  assign prod_sh   = prod >>> (MW - 1);
  assign unused_hi = ^prod_sh[PW-1:AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      exp_q <= '0;
    end else if (s1_en_i) begin
      acc_q <= prod_sh[AW-1:0];
      exp_q <= exp_i;
    end
  end

  assign ext  = {{(SW-AW){acc_q[AW-1]}}, acc_q};
  assign wide = ext <<< exp_q;
  // overflow when the bits above the output sign are not a pure sign extension
  assign ovf  = !(&wide[SW-1:DW-1]) && (|wide[SW-1:DW-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o <= '0;
    end else if (s2_en_i) begin
      if (ovf) y_o <= wide[SW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
      else     y_o <= wide[DW-1:0];
    end
  end
endmodule

// File: rtl/agc_gain_loop.sv
module agc_gain_loop
  import agc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 auto_i,
  input  logic                 upd_i,
  input  logic [GAIN_W-1:0]    held_i,
  input  logic [GAIN_W-1:0]    ceil_i,
  input  logic [GAIN_W-1:0]    floor_i,
  input  logic [GAIN_W-1:0]    slew_i,
  input  logic [DW-1:0]        target_i,
  input  logic signed [DW-1:0] smp_i_i,
  input  logic signed [DW-1:0] smp_q_i,
  output logic [GAIN_W-1:0]    gain_o
);
  logic [DW:0]       xi, xq, ai, aq;
  logic [DW+1:0]     lvl, tgt;
  logic [GAIN_W:0]   up_sum;
  logic [GAIN_W-1:0] stepped, nxt;

  assign xi  = {smp_i_i[DW-1], smp_i_i};
  assign xq  = {smp_q_i[DW-1], smp_q_i};
  assign ai  = xi[DW] ? (~xi + 1'b1) : xi;
  assign aq  = xq[DW] ? (~xq + 1'b1) : xq;
  assign lvl = {1'b0, ai} + {1'b0, aq};
  assign tgt = {2'b00, target_i};
  assign up_sum = {1'b0, gain_o} + {1'b0, slew_i};

  always_comb begin
    if (lvl > tgt)      stepped = (gain_o >= slew_i) ? gain_o - slew_i : '0;
    else if (lvl < tgt) stepped = up_sum[GAIN_W] ? '1 : up_sum[GAIN_W-1:0];
    else                stepped = gain_o;
    nxt = stepped;
    if (nxt > ceil_i)  nxt = ceil_i;
    if (nxt < floor_i) nxt = floor_i;  // floor wins on inverted limits
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gain_o <= GAIN_UNITY;
    else if (!auto_i) gain_o <= held_i;
    else if (upd_i)  gain_o <= nxt;
  end
endmodule

// File: rtl/agc_scaler.sv
module agc_scaler
  import agc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic signed [DW-1:0] in_i_i,
  input  logic signed [DW-1:0] in_q_i,
  input  logic                 cfg_we_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [DW-1:0]        cfg_wdata_i,
  output logic                 out_valid_o,
  output logic signed [DW-1:0] out_i_o,
  output logic signed [DW-1:0] out_q_o,
  output logic [GAIN_W-1:0]    level_o
);
  localparam int LANES = 2;

  logic              mode_auto;
  logic [GAIN_W-1:0] held_g, lim_hi, lim_lo, slew_g, gain_q, eff_gain;
  logic [DW-1:0]     target_lvl;
  logic              v1_q;
  logic signed [DW-1:0] lane_x [LANES];
  logic signed [DW-1:0] lane_y [LANES];

  agc_cfg_regs #(.DW(DW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .auto_o(mode_auto), .held_o(held_g), .ceil_o(lim_hi), .floor_o(lim_lo),
    .slew_o(slew_g), .target_o(target_lvl)
  );

  assign eff_gain = mode_auto ? gain_q : held_g;
  assign level_o  = eff_gain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q        <= 1'b0;
      out_valid_o <= 1'b0;
    end else begin
      v1_q        <= in_valid_i;
      out_valid_o <= v1_q;
    end
  end

  assign lane_x[0] = in_i_i;
  assign lane_x[1] = in_q_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    agc_scale_lane #(.DW(DW), .MW(GAIN_MAN_W), .EW(GAIN_EXP_W)) u_lane (
      .clk_i, .rst_ni,
      .s1_en_i(in_valid_i), .s2_en_i(v1_q),
      .x_i(lane_x[l]),
      .man_i(eff_gain[GAIN_MAN_W-1:0]),
      .exp_i(eff_gain[GAIN_W-1:GAIN_MAN_W]),
      .y_o(lane_y[l])
    );
  end

  assign out_i_o = lane_y[0];
  assign out_q_o = lane_y[1];

  agc_gain_loop #(.DW(DW)) u_loop (
    .clk_i, .rst_ni,
    .auto_i(mode_auto), .upd_i(out_valid_o),
    .held_i(held_g), .ceil_i(lim_hi), .floor_i(lim_lo), .slew_i(slew_g),
    .target_i(target_lvl), .smp_i_i(out_i_o), .smp_q_i(out_q_o),
    .gain_o(gain_q)
  );
endmodule

// File: rtl/agc_scaler_chk.sv
module agc_scaler_chk #(
  parameter int GW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          out_valid_o,
  input logic [GW-1:0] level_o,
  input logic          auto_i,
  input logic [GW-1:0] gain_i,
  input logic [GW-1:0] hi_i,
  input logic [GW-1:0] lo_i
);
  // R4
  lat_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##2 out_valid_o);

  // R4
  lat_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##2 !out_valid_o);

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && $past(auto_i) && !$past(out_valid_o)) |-> $stable(level_o));

  // R7
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && $past(auto_i) && $past(out_valid_o) && $stable(hi_i) && $stable(lo_i)
     && lo_i <= hi_i) |-> (gain_i >= lo_i && gain_i <= hi_i));

  // R8
  inverted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && $past(auto_i) && $past(out_valid_o) && $stable(hi_i) && $stable(lo_i)
     && lo_i > hi_i) |-> (gain_i == lo_i));
endmodule

bind agc_scaler agc_scaler_chk #(.GW(agc_pkg::GAIN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .out_valid_o(out_valid_o),
  .level_o(level_o), .auto_i(mode_auto), .gain_i(gain_q), .hi_i(lim_hi), .lo_i(lim_lo)
);

// File: tb/agc_scaler_bench.sv
module agc_scaler_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;
  logic [11:0] level;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  agc_scaler u_agc_scaler (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_i_i(in_i), .in_q_i(in_q),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .out_valid_o(out_valid), .out_i_o(out_i), .out_q_o(out_q), .level_o(level)
  );

  // behavioural reference
  int m_auto, m_held, m_hi, m_lo, m_slew, m_tgt, m_gain;
  int s1_v, s1_i, s1_q, o_v, o_i, o_q;

  function automatic int scale(int x, int g);
    longint p;
    p = longint'(x) * longint'(g % 256);
    p = p >>> 7;
    p = p * (longint'(1) << (g / 256));
    if (p > 32767) return 32767;
    if (p < -32768) return -32768;
    return int'(p);
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int eff();
    return (m_auto != 0) ? m_gain : m_held;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_auto = 0; m_held = 128; m_hi = 4095; m_lo = 0; m_slew = 1; m_tgt = 16384;
      m_gain = 128; s1_v = 0; s1_i = 0; s1_q = 0; o_v = 0; o_i = 0; o_q = 0;
    end else begin
      int g, n_v, n_i, n_q, lvl;
      g = eff();
      n_v = in_valid; n_i = 0; n_q = 0;
      if (in_valid) begin n_i = scale(int'(in_i), g); n_q = scale(int'(in_q), g); end
      if (m_auto == 0) m_gain = m_held;
      else if (o_v != 0) begin
        lvl = iabs(o_i) + iabs(o_q);
        if (lvl > m_tgt) m_gain = (m_gain - m_slew < 0) ? 0 : m_gain - m_slew;
        else if (lvl < m_tgt) m_gain = (m_gain + m_slew > 4095) ? 4095 : m_gain + m_slew;
        if (m_gain > m_hi) m_gain = m_hi;
        if (m_gain < m_lo) m_gain = m_lo;
      end
      if (s1_v != 0) begin o_i = s1_i; o_q = s1_q; end
      o_v = s1_v;
      s1_v = n_v;
      if (n_v != 0) begin s1_i = n_i; s1_q = n_q; end
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: m_auto = int'(cfg_wdata[0]);
          3'd1: m_held = int'(cfg_wdata[11:0]);
          3'd2: m_hi   = int'(cfg_wdata[11:0]);
          3'd3: m_lo   = int'(cfg_wdata[11:0]);
          3'd4: m_slew = int'(cfg_wdata[11:0]);
          3'd5: m_tgt  = int'(cfg_wdata);
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (int'(out_valid) != o_v) begin
        bad++; $display("FAIL R4 out_valid actual=%0d expected=%0d", out_valid, o_v);
      end
      if (o_v != 0) begin
        total++;
        if (int'(out_i) != o_i || int'(out_q) != o_q) begin
          bad++; $display("FAIL R2 out actual=%0d,%0d expected=%0d,%0d", out_i, out_q, o_i, o_q);
        end
      end
      total++;
      if (int'(level) != eff()) begin
        bad++; $display("FAIL R10 level actual=%0h expected=%0h", level, eff());
      end
    end
  end

  task automatic chk(string tag, int act, int exp_v);
    total++;
    if (act != exp_v) begin
      bad++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one sample; returns at the negedge where its result is visible
  task automatic send(int xi, int xq);
    @(negedge clk);
    in_valid = 1'b1; in_i = 16'(xi); in_q = 16'(xq);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_chk(string tag, int xi, int xq, int ei, int eq);
    send(xi, xq);
    chk(tag, int'(out_valid), 1);
    chk(tag, int'(out_i), ei);
    chk(tag, int'(out_q), eq);
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 level", int'(level), 128);
    rst_n = 1'b1;
    @(negedge clk);

    send_chk("R2 unity", 1234, -567, 1234, -567);
    // R5 new held gain applies to next sample
    wr(1, 16'h0C8);
    send_chk("R5 held write", -1000, 300, -1563, 468);
    chk("R10 level", int'(level), 16'h0C8);
    wr(1, 16'h240);
    send_chk("R2 exponent", 1001, -3, 2000, -8);
    // R3 saturation both ways
    wr(1, 16'hFFF);
    send_chk("R3 sat", 5, -5, 32767, -32768);
    @(negedge clk);
    chk("R4 single pulse", int'(out_valid), 0);
    // R11 ignored addresses leave gain unchanged
    wr(6, 16'h0123);
    wr(7, 16'h0456);
    chk("R11 ignored", int'(level), 16'hFFF);

    // R9 loop starts from held value
    wr(1, 16'h090);
    wr(0, 1);
    chk("R9 start", int'(level), 16'h090);
    wr(0, 0);
    wr(1, 16'h080);
    wr(5, 100);
    wr(4, 4);
    wr(2, 16'h0A0);
    wr(3, 16'h070);
    wr(0, 1);
    // R6 equal level holds
    send(100, 0);
    @(negedge clk);
    chk("R6 hold", int'(level), 16'h080);
    send(10, 0);
    @(negedge clk);
    chk("R6 step up", int'(level), 16'h084);
    for (int k = 0; k < 10; k++) begin send(10, 0); @(negedge clk); end
    chk("R7 ceiling", int'(level), 16'h0A0);
    send_chk("R3 loop sat", -30000, 30000, -32768, 32767);
    @(negedge clk);
    chk("R6 step down", int'(level), 16'h09C);
    wr(3, 16'h0B0);
    send(10, 0);
    @(negedge clk);
    chk("R8 inverted", int'(level), 16'h0B0);
    send(30000, 0);
    @(negedge clk);
    chk("R8 inverted down", int'(level), 16'h0B0);

    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 1) == 1);
      in_i = 16'($urandom);
      in_q = 16'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        cfg_we = 1'b1;
        cfg_addr = 3'($urandom_range(0, 7));
        cfg_wdata = 16'($urandom);
        if (cfg_addr == 3'd4) cfg_wdata = 16'($urandom_range(0, 64));
      end else begin
        cfg_we = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    repeat (4) @(negedge clk);

    done = 1;
    report();
    $finish;
  end
endmodule